// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block sits inside a controller for an asynchronous page-mode DRAM and takes care of everything that keeps the memory alive. After reset it holds off for a programmable power-up pause. It then asks the access arbiter for a fixed number of wake-up refresh cycles and raises `init_done` once they are complete. After that it asks for one refresh cycle per refresh interval, so that all 512 rows are refreshed within the retention window.

Requests that the arbiter cannot serve at once are counted in a saturating pending counter. When the count reaches a threshold, an urgency flag asks the arbiter to give refresh priority. If the counter is already full and another interval expires, the retention deadline is taken as missed. `init_done` then drops and the wake-up sequence is run again. While a granted cycle is in progress the block drives the RAS, both CAS strobes, WE and the address.

Two refresh styles are available, chosen by a configuration input that is sampled during reset:
- In CAS-before-RAS mode, both CAS strobes fall before RAS.
- In RAS-only mode, the CAS strobes stay high and the block drives the row address from its own row counter.

All timing is expressed in nanoseconds and turned into clock counts using the clock-period parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and when idle, `ras_n`, `lcas_n`, `ucas_n` and `we_n` are high, `addr` is 0, and `init_done`, `ref_req` and `ref_urgent` are low.
- R2: After reset is released, `ref_req` stays low for exactly PAUSE_NS/CLK_NS clock cycles and rises on the next cycle.
- R3: Exactly WAKE_CYCLES refresh cycles (8 by default) are run after the pause, and `init_done` rises only after the last one.
- R4: In CAS-before-RAS mode (`cfg_ras_only`=0 at reset), both CAS strobes are low for at least ceil(CAS_SU_NS/CLK_NS) cycles before RAS falls. They stay low for exactly ceil(CAS_HO_NS/CLK_NS) cycles of the RAS low time. `we_n` stays high and `addr` is 0.
- R5: RAS stays low for exactly ceil(RAS_LOW_NS/CLK_NS) cycles, and each RAS precharge lasts at least ceil(RAS_PRE_NS/CLK_NS) cycles.
- R6: No refresh cycle starts without `ref_gnt`. `ref_req` is high only while all strobes are idle.
- R7: After `init_done`, with the grant held high, exactly one refresh cycle is run per INTERVAL_NS/CLK_NS clock cycles.
- R8: Interval expiries that are not served accumulate, up to PEND_MAX. `ref_urgent` is high when the count is at least PEND_URGENT. Once the grant returns, the pending cycles are run back to back, and `ref_req` then falls.
- R9: If an interval expires while PEND_MAX refreshes are already pending, `init_done` falls and the full wake-up sequence is repeated before it rises again.
- R10: In RAS-only mode (`cfg_ras_only`=1 at reset), both CAS strobes stay high. Each RAS fall drives the row counter on `addr`. The counter starts at 0 after reset, advances by one per cycle and wraps from 511 to 0.
- R11: `cfg_ras_only` takes effect only during reset; changing it afterwards does not change the refresh style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ras_only | input | 1 | Refresh style, sampled in reset: 1 = RAS-only, 0 = CAS-before-RAS |
| ref_gnt | input | 1 | Arbiter grant; a grant seen while `ref_req` is high commits one full refresh cycle |
| ref_req | output | 1 | Refresh cycle wanted |
| ref_urgent | output | 1 | Pending count at or above the threshold |
| init_done | output | 1 | Wake-up sequence complete |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address during RAS-only cycles, else 0 |

## Verification
The hardest state to reach is a missed retention deadline. Reaching it needs the pending counter full and one more interval expiring with no grant. The bench withholds the grant for several intervals and bounds the time until `init_done` falls. It then restores the grant and counts the wake-up cycles that follow. The row-counter wrap is also costly to reach, since it needs 512 refresh cycles. The bench gets there by running the RAS-only configuration with a shortened interval while checking every row address.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_NS      = 10,
  parameter int PAUSE_NS    = 200000,
  parameter int INTERVAL_NS = 15625,
  parameter int RAS_LOW_NS  = 35,
  parameter int RAS_PRE_NS  = 25,
  parameter int CAS_SU_NS   = 8,
  parameter int CAS_HO_NS   = 8,
  parameter int WAKE_CYCLES = 8,
  parameter int PEND_MAX    = 7,
  parameter int PEND_URGENT = 4,
  parameter int ROW_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ras_only,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             init_done,
  output logic             ras_n,
  output logic             lcas_n,
  output logic             ucas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);
  localparam int PAUSE_C = (PAUSE_NS / CLK_NS) < 1 ? 1 : PAUSE_NS / CLK_NS;
  localparam int INTV_C  = (INTERVAL_NS / CLK_NS) < 1 ? 1 : INTERVAL_NS / CLK_NS;
  localparam int RAS_C   = (RAS_LOW_NS + CLK_NS - 1) / CLK_NS;
  localparam int PRE_C   = (RAS_PRE_NS + CLK_NS - 1) / CLK_NS;
  localparam int CSU_C   = (CAS_SU_NS + CLK_NS - 1) / CLK_NS < 1 ? 1 : (CAS_SU_NS + CLK_NS - 1) / CLK_NS;
  localparam int CHO_C   = (CAS_HO_NS + CLK_NS - 1) / CLK_NS < 1 ? 1 : (CAS_HO_NS + CLK_NS - 1) / CLK_NS;
  localparam int TW      = $clog2(PAUSE_C + INTV_C + RAS_C + PRE_C + CSU_C + 1);
  localparam int PW      = $clog2(PEND_MAX + 1);
  localparam int WW      = $clog2(WAKE_CYCLES + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_LEAD, S_ACT, S_PRE} st_t;

  st_t             st;
  logic [TW-1:0]   tmr, itv;
  logic [PW-1:0]   pend;
  logic [WW-1:0]   wake_left;
  logic            init_q, mode_q, ras_q, cas_q;
  logic [ROW_W-1:0] row_q, addr_q;

  assign ref_req    = (st == S_IDLE) && (init_q ? (pend != '0) : (wake_left != '0));
  assign ref_urgent = init_q && (pend >= PW'(PEND_URGENT));
  assign init_done  = init_q;
  assign ras_n      = ras_q;
  assign lcas_n     = cas_q;
  assign ucas_n     = cas_q;
  assign we_n       = 1'b1;
  assign addr       = addr_q;

  wire start = ref_req && ref_gnt;
  wire take  = start && init_q;
  wire tick  = init_q && (itv == TW'(INTV_C - 1));
  wire miss  = tick && !take && (pend == PW'(PEND_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      tmr       <= '0;
      itv       <= '0;
      pend      <= '0;
      wake_left <= WW'(WAKE_CYCLES);
      init_q    <= 1'b0;
      mode_q    <= cfg_ras_only;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      row_q     <= '0;
      addr_q    <= '0;
    end else begin
      itv <= (!init_q || tick) ? '0 : itv + 1'b1;

      if (tick && !take && pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
      else if (!tick && take)                     pend <= pend - 1'b1;

      if (start && !init_q) wake_left <= wake_left - 1'b1;

      case (st)
        S_PAUSE: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(PAUSE_C - 1)) begin
            st  <= S_IDLE;
            tmr <= '0;
          end
        end
        S_IDLE: if (start) begin
          st     <= S_LEAD;
          tmr    <= '0;
          cas_q  <= mode_q;
          addr_q <= mode_q ? row_q : '0;
        end
        S_LEAD: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(CSU_C - 1)) begin
            st    <= S_ACT;
            tmr   <= '0;
            ras_q <= 1'b0;
          end
        end
        S_ACT: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(CHO_C - 1)) cas_q <= 1'b1;
          if (tmr == TW'(RAS_C - 1)) begin
            st     <= S_PRE;
            tmr    <= '0;
            ras_q  <= 1'b1;
            cas_q  <= 1'b1;
            addr_q <= '0;
            if (mode_q) row_q <= row_q + 1'b1;
          end
        end
        S_PRE: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(PRE_C - 1)) begin
            st  <= S_IDLE;
            tmr <= '0;
            if (!init_q && wake_left == '0) init_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (miss) begin
        pend      <= '0;
        init_q    <= 1'b0;
        wake_left <= WW'(WAKE_CYCLES);
      end
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mode,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n,
  input logic ref_req,
  input logic ref_urgent,
  input logic init_done
);
  assert_cas_idle_rasonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> (lcas_n && ucas_n));

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !mode) |-> (!lcas_n && !ucas_n && $past(!lcas_n && !ucas_n)));

  assert_ras_low_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !ras_n);

  assert_ras_pre_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  assert_req_pins_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (ras_n && lcas_n && ucas_n));

  assert_urgent_after_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> init_done);

  assert_init_rise_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ras_n && lcas_n && ucas_n));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .ras_n(ras_n), .lcas_n(lcas_n),
  .ucas_n(ucas_n), .ref_req(ref_req), .ref_urgent(ref_urgent), .init_done(init_done)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb_top;
  localparam int CLK_NS = 10;
  localparam int PAUSE_C = 50;
  localparam int INTV_C = 100;
  localparam int RAS_C = 4;
  localparam int PRE_C = 3;
  localparam int CSU_C = 1;
  localparam int CHO_C = 1;
  localparam int PMAX = 6;

  logic clk = 0, rst_n = 0, cfg = 0, gnt = 0;
  logic req, urg, done, ras_n, lcas_n, ucas_n, we_n;
  logic [8:0] addr;

  int errors = 0, checks = 0, falls = 0;
  bit mode_exp = 0, wrapped = 0, finished = 0;
  int exp_row = 0, lowlen = 0, highlen = 1000, caslead = 0, caslow = 0;
  logic prev_ras = 1;

  always #(CLK_NS/2) clk = ~clk;

  dram_refresh_seq #(.CLK_NS(CLK_NS), .PAUSE_NS(500), .INTERVAL_NS(1000),
    .PEND_MAX(PMAX), .PEND_URGENT(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ras_only(cfg), .ref_gnt(gnt),
    .ref_req(req), .ref_urgent(urg), .init_done(done), .ras_n(ras_n),
    .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n), .addr(addr));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; exp_row = 0; lowlen = 0; highlen = 1000; caslead = 0; caslow = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        falls++;
        chk(we_n == 1'b1, "R4 we_n high", we_n, 1);
        chk(highlen >= PRE_C, "R5 precharge", highlen, PRE_C);
        if (mode_exp) begin
          chk(lcas_n && ucas_n, "R10 cas high", {lcas_n, ucas_n}, 3);
          chk(addr == exp_row[8:0], "R10 row addr", addr, exp_row);
          if (exp_row == 511) wrapped = 1;
          exp_row = (exp_row + 1) % 512;
        end else begin
          chk(!lcas_n && !ucas_n, "R4 cas low at ras fall", {lcas_n, ucas_n}, 0);
          chk(caslead >= CSU_C, "R4 cas setup", caslead, CSU_C);
          chk(addr == 0, "R4 addr zero", addr, 0);
        end
        lowlen = 0; caslow = 0;
      end
      if (!ras_n) begin
        lowlen++;
        if (!lcas_n) caslow++;
      end
      if (!prev_ras && ras_n) begin
        chk(lowlen == RAS_C, "R5 ras low width", lowlen, RAS_C);
        if (!mode_exp) chk(caslow == CHO_C, "R4 cas hold", caslow, CHO_C);
        highlen = 0;
      end
      if (ras_n) begin
        highlen++;
        if (!lcas_n) caslead++; else caslead = 0;
      end
      prev_ras = ras_n;
    end
  end

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 0; cfg = m; gnt = 0; mode_exp = m;
    repeat (3) @(negedge clk);
    chk(ras_n && lcas_n && ucas_n && we_n, "R1 strobes high in reset", {ras_n, lcas_n, ucas_n, we_n}, 15);
    chk(!done && !req && !urg && addr == 0, "R1 flags low in reset", {done, req, urg}, 0);
    rst_n = 1;
  endtask

  task automatic t_pause;
    int n = 0;
    while (!req && n < 1000) begin
      @(negedge clk); n++;
    end
    chk(n == PAUSE_C, "R2 pause length", n, PAUSE_C);
    chk(ras_n && lcas_n && ucas_n, "R1 idle strobes", {ras_n, lcas_n, ucas_n}, 7);
  endtask

  task automatic t_nogrant;
    int f0 = falls;
    repeat (30) @(negedge clk);
    chk(falls == f0, "R6 no cycle without grant", falls - f0, 0);
    chk(req == 1'b1, "R6 request held", req, 1);
  endtask

  task automatic t_wake;
    int f0 = falls, n = 0;
    gnt = 1;
    while (!done && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(done == 1'b1, "R3 init_done rises", done, 1);
    chk(falls - f0 == 8, "R3 wake cycles", falls - f0, 8);
  endtask

  task automatic t_pending;
    int n = 0, f0;
    repeat (150) @(negedge clk);
    gnt = 0;
    while (!req && n < 500) begin
      @(negedge clk); n++;
    end
    repeat (INTV_C + INTV_C/2) @(negedge clk);
    chk(urg == 1'b0, "R8 urgent low at 2 pending", urg, 0);
    repeat (INTV_C) @(negedge clk);
    chk(urg == 1'b1, "R8 urgent high at 3 pending", urg, 1);
    f0 = falls;
    gnt = 1;
    repeat (45) @(negedge clk);
    chk(falls - f0 == 3, "R8 drained cycles", falls - f0, 3);
    chk(req == 1'b0 && urg == 1'b0, "R8 request drops after drain", {req, urg}, 0);
  endtask

  task automatic t_periodic;
    int f0;
    repeat (60) @(negedge clk);
    f0 = falls;
    repeat (10 * INTV_C) @(negedge clk);
    chk(falls - f0 == 10, "R7 one refresh per interval", falls - f0, 10);
  endtask

  task automatic t_miss;
    int n = 0, f0;
    gnt = 0;
    while (done && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(done == 1'b0, "R9 init_done falls on miss", done, 0);
    chk(n >= PMAX * INTV_C && n <= (PMAX + 2) * INTV_C, "R9 miss timing", n, (PMAX + 1) * INTV_C);
    f0 = falls; n = 0;
    gnt = 1;
    while (!done && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(done == 1'b1 && falls - f0 == 8, "R9 wake repeated", falls - f0, 8);
  endtask

  task automatic t_rasonly;
    int n = 0;
    do_reset(1);
    @(negedge clk);
    cfg = 0;
    gnt = 1;
    while (falls < 530 && n < 90000) begin
      @(negedge clk); n++;
    end
    chk(wrapped == 1'b1, "R10 row counter wrapped", wrapped, 1);
    chk(exp_row >= 9 && exp_row < 40, "R10 rows after wrap", exp_row, 18);
    chk(lcas_n && ucas_n, "R11 mode kept after cfg change", {lcas_n, ucas_n}, 3);
  endtask

  initial begin
    do_reset(0);
    t_pause;
    t_nogrant;
    t_wake;
    t_pending;
    t_periodic;
    t_miss;
    falls = 0;
    t_rasonly;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule